// File: doc/BRIEF.md
# Branch Target Buffer with Two-Bit Direction Counters

This block sits beside the instruction fetch stage. It guesses, before an instruction is decoded, whether the instruction at the fetch address is a control transfer that will be taken, and where it will go. It is a direct-mapped table indexed by word-address bits of the fetch PC. Each slot holds a valid bit, the complete instruction address of a branch or jump, that instruction's last known destination, and a two-bit saturating direction counter. Fetch logic presents its PC and receives a hit flag, a taken guess, the stored destination, and the chosen next fetch address. That address is the stored destination when the entry hits and predicts taken, and the sequential address (PC plus 4) in every other case.

When a branch or jump resolves later in the pipeline, the resolving stage drives the update port with the instruction address, the real destination, the real direction and a jump flag. In the same cycle the block checks the table's current guess for that address against the real outcome. When they differ it raises a squash output together with the correct restart address. At the next clock edge it trains the table. A jump is always treated as taken.

Top module: `btb`

## Requirements
- R1: After a synchronous active-low reset every entry is invalid: no lookup hits, and the next fetch address is the lookup PC plus 4.
- R2: The table index is PC bits [INDEX_W+1:2]. A lookup hits only if the slot at that index is valid and its stored address equals the whole lookup PC, so a different address that shares the index misses.
- R3: A lookup that hits with counter value 2 or 3 reports predict-taken and selects the stored target as the next fetch address. Any other lookup selects the PC plus 4.
- R4: A taken conditional branch that misses the table is allocated with counter 2 (weakly taken), so a single later not-taken resolution makes it predict not-taken.
- R5: A resolved jump is written with counter 3 (strongly taken), so one following not-taken branch resolution at that address still leaves it predicting taken.
- R6: On a hit, a branch resolution moves the counter up by one when taken and down by one when not taken, holding at 3 and at 0.
- R7: A not-taken conditional branch that misses the table allocates nothing.
- R8: During an update the squash output is high exactly when the table's current guess for that address is wrong: the guess was not-taken but the outcome is taken, the guess was taken but the outcome is not-taken, or both are taken but the destinations differ. The restart output gives the real target when the outcome is taken and the instruction address plus 4 otherwise. Squash stays low when no update is presented.
- R9: A taken resolution that hits replaces the stored target with the real target.
- R10: A lookup in the same cycle as an update to the same slot returns the slot's contents from before that update.
- R11: The predict-taken output is never high without the hit output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_pc | input | ADDR_W | Address being fetched |
| fetch_hit | output | 1 | Valid slot with matching address |
| fetch_taken | output | 1 | Hit and counter predicts taken |
| fetch_target | output | ADDR_W | Stored destination of the matching slot |
| fetch_next_pc | output | ADDR_W | Chosen next fetch address |
| res_valid | input | 1 | A resolution is presented this cycle |
| res_pc | input | ADDR_W | Address of the resolved instruction |
| res_target | input | ADDR_W | Real destination of the instruction |
| res_taken | input | 1 | Real direction (1 = taken) |
| res_is_jump | input | 1 | Resolved instruction is an unconditional jump |
| squash | output | 1 | Table guess was wrong; discard younger fetches |
| restart_pc | output | ADDR_W | Correct address to resume fetch from |

## Verification
Resolution streams are driven at several slot addresses. A run of taken outcomes followed by not-taken outcomes, and the reverse, shows the counter holding at both ends and the weak-versus-strong starting values for branches and jumps. Two addresses that share an index tell full-address matching apart from index-only matching. A taken outcome to a new destination separates a direction error from a target error in the squash decision. A lookup presented in the same cycle as a write to its own slot shows whether reads see old or new contents.

// File: rtl/btb_pkg.sv
// Package btb_pkg
// Holds the counter type and its named values, which all BTB modules share.
// Assumes a two-bit counter. Values with the high bit set predict taken.
package btb_pkg;
    typedef logic [1:0] ctr_t;
    localparam ctr_t CTR_STRONG_NT = 2'd0;
    localparam ctr_t CTR_WEAK_T    = 2'd2;
    localparam ctr_t CTR_STRONG_T  = 2'd3;
endpackage

// File: rtl/btb_counter.sv
// Module btb_counter
// Computes the next value of a two-bit saturating direction counter.
// Assumes the caller writes the result only for a slot that hit.
module btb_counter
    import btb_pkg::*;
(
    input  ctr_t cur,
    input  logic taken,
    output ctr_t nxt
);
    // Step up or down, holding at the two ends.
    always_comb begin
        nxt = cur;
        if (taken && cur != CTR_STRONG_T)
            nxt = cur + 2'd1;
        else if (!taken && cur != CTR_STRONG_NT)
            nxt = cur - 2'd1;
    end
endmodule

// File: rtl/btb_store.sv
// Module btb_store
// Holds the slot array: one write port and RD_PORTS combinational read ports.
// Assumes reads return the contents from before the write on the same edge.
// Only the valid bits are reset; the other fields are don't-care until written.
module btb_store
    import btb_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int INDEX_W  = 4,
    parameter int RD_PORTS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [INDEX_W-1:0] wr_idx,
    input  logic [ADDR_W-1:0] wr_tag,
    input  logic [ADDR_W-1:0] wr_tgt,
    input  ctr_t              wr_ctr,
    input  logic [INDEX_W-1:0] rd_idx [RD_PORTS],
    output logic              rd_valid [RD_PORTS],
    output logic [ADDR_W-1:0] rd_tag [RD_PORTS],
    output logic [ADDR_W-1:0] rd_tgt [RD_PORTS],
    output ctr_t              rd_ctr [RD_PORTS]
);
    localparam int ENTRIES = 1 << INDEX_W;

    logic [ENTRIES-1:0] valid_q;
    logic [ADDR_W-1:0]  tag_q [ENTRIES];
    logic [ADDR_W-1:0]  tgt_q [ENTRIES];
    ctr_t               ctr_q [ENTRIES];

    // Valid bits: cleared by reset, set when a slot is written.
    always_ff @(posedge clk) begin
        if (!rst_n)
            valid_q <= '0;
        else if (wr_en)
            valid_q[wr_idx] <= 1'b1;
    end

    // Slot fields: written with no reset.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx] <= wr_tag;
            tgt_q[wr_idx] <= wr_tgt;
            ctr_q[wr_idx] <= wr_ctr;
        end
    end

    for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
        assign rd_valid[p] = valid_q[rd_idx[p]];
        assign rd_tag[p]   = tag_q[rd_idx[p]];
        assign rd_tgt[p]   = tgt_q[rd_idx[p]];
        assign rd_ctr[p]   = ctr_q[rd_idx[p]];
    end
endmodule

// File: rtl/btb_match.sv
// Module btb_match
// Turns one read-out slot into hit, taken guess and target for a given address.
// Assumes the slot was read at the index taken from that same address.
module btb_match
    import btb_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic              valid,
    input  logic [ADDR_W-1:0] tag,
    input  logic [ADDR_W-1:0] tgt,
    input  ctr_t              ctr,
    output logic              hit,
    output logic              pred_taken,
    output logic [ADDR_W-1:0] target
);
    // Compare the whole address and read the direction from the counter MSB.
    always_comb begin
        hit        = valid && (tag == pc);
        pred_taken = hit && ctr[1];
        target     = tgt;
    end
endmodule

// File: rtl/btb.sv
// Module btb
// Direct-mapped branch target buffer for the fetch stage. It has a lookup port
// and a resolution port. The resolution port reports a wrong guess and trains
// the table. Assumes instruction addresses are word aligned (bits [1:0] zero),
// and that an update's guess equals the one fetch saw, which holds when no other
// write to that slot falls in between.
module btb
    import btb_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int INDEX_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] fetch_pc,
    output logic              fetch_hit,
    output logic              fetch_taken,
    output logic [ADDR_W-1:0] fetch_target,
    output logic [ADDR_W-1:0] fetch_next_pc,
    input  logic              res_valid,
    input  logic [ADDR_W-1:0] res_pc,
    input  logic [ADDR_W-1:0] res_target,
    input  logic              res_taken,
    input  logic              res_is_jump,
    output logic              squash,
    output logic [ADDR_W-1:0] restart_pc
);
    localparam int RD_PORTS = 2;
    localparam int P_FETCH  = 0;
    localparam int P_RES    = 1;
    localparam logic [ADDR_W-1:0] INSN_BYTES = ADDR_W'(4);

    logic [INDEX_W-1:0] rd_idx   [RD_PORTS];
    logic               rd_valid [RD_PORTS];
    logic [ADDR_W-1:0]  rd_tag   [RD_PORTS];
    logic [ADDR_W-1:0]  rd_tgt   [RD_PORTS];
    ctr_t               rd_ctr   [RD_PORTS];
    logic [ADDR_W-1:0]  port_pc  [RD_PORTS];
    logic               port_hit [RD_PORTS];
    logic               port_tk  [RD_PORTS];
    logic [ADDR_W-1:0]  port_tgt [RD_PORTS];

    logic               wr_en;
    logic [ADDR_W-1:0]  wr_tgt;
    ctr_t               wr_ctr;
    ctr_t               ctr_step;
    logic               res_hit;
    logic               res_eff_taken;

    assign port_pc[P_FETCH] = fetch_pc;
    assign port_pc[P_RES]   = res_pc;

    for (genvar p = 0; p < RD_PORTS; p++) begin : g_port
        assign rd_idx[p] = port_pc[p][INDEX_W+1:2];
        btb_match #(.ADDR_W(ADDR_W)) i_match (
            .pc(port_pc[p]), .valid(rd_valid[p]), .tag(rd_tag[p]),
            .tgt(rd_tgt[p]), .ctr(rd_ctr[p]), .hit(port_hit[p]),
            .pred_taken(port_tk[p]), .target(port_tgt[p])
        );
    end

    btb_store #(.ADDR_W(ADDR_W), .INDEX_W(INDEX_W), .RD_PORTS(RD_PORTS)) i_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(res_pc[INDEX_W+1:2]),
        .wr_tag(res_pc), .wr_tgt(wr_tgt), .wr_ctr(wr_ctr),
        .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_tag(rd_tag),
        .rd_tgt(rd_tgt), .rd_ctr(rd_ctr)
    );

    btb_counter i_ctr (.cur(rd_ctr[P_RES]), .taken(res_taken), .nxt(ctr_step));

    // Fetch side: hit, guess and the choice of next fetch address.
    always_comb begin
        fetch_hit     = port_hit[P_FETCH];
        fetch_taken   = port_tk[P_FETCH];
        fetch_target  = port_tgt[P_FETCH];
        fetch_next_pc = fetch_taken ? fetch_target : fetch_pc + INSN_BYTES;
    end

    // Resolution side: compare the current guess with the real outcome.
    always_comb begin
        res_hit       = port_hit[P_RES];
        res_eff_taken = res_taken || res_is_jump;
        squash        = 1'b0;
        if (res_valid) begin
            if (res_eff_taken)
                squash = !(port_tk[P_RES] && port_tgt[P_RES] == res_target);
            else
                squash = port_tk[P_RES];
        end
        restart_pc = res_eff_taken ? res_target : res_pc + INSN_BYTES;
    end

    // Training: decide whether to write, and the counter and target to write.
    always_comb begin
        wr_en  = 1'b0;
        wr_ctr = ctr_step;
        wr_tgt = res_target;
        if (res_valid) begin
            if (res_is_jump) begin
                wr_en  = 1'b1;
                wr_ctr = CTR_STRONG_T;
            end else if (res_hit) begin
                wr_en  = 1'b1;
                wr_tgt = res_taken ? res_target : port_tgt[P_RES];
            end else if (res_taken) begin
                wr_en  = 1'b1;
                wr_ctr = CTR_WEAK_T;
            end
        end
    end
endmodule

// File: rtl/btb_checker.sv
// Module btb_checker
// Timing and port-relation properties for btb, bound into every instance.
// Assumes it sees the top-level ports plus the resolution-side hit signal.
module btb_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] fetch_pc,
    input logic              fetch_hit,
    input logic              fetch_taken,
    input logic [ADDR_W-1:0] fetch_target,
    input logic [ADDR_W-1:0] fetch_next_pc,
    input logic              res_valid,
    input logic [ADDR_W-1:0] res_pc,
    input logic              res_taken,
    input logic              res_is_jump,
    input logic              res_hit,
    input logic              squash
);
    assert_reset_empty_R1: assert property (@(posedge clk)
        !rst_n |=> !fetch_hit);

    assert_seq_next_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_taken |-> fetch_next_pc == fetch_pc + ADDR_W'(4));

    assert_tgt_next_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_taken |-> fetch_next_pc == fetch_target);

    assert_nt_miss_no_alloc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_taken && !res_is_jump && !res_hit)
        |=> (fetch_pc != $past(res_pc) || !fetch_hit));

    assert_nt_miss_no_squash_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_taken && !res_is_jump && !res_hit) |-> !squash);

    assert_squash_needs_update_R8: assert property (@(posedge clk) disable iff (!rst_n)
        squash |-> res_valid);

    assert_taken_needs_hit_R11: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_taken |-> fetch_hit);
endmodule

bind btb btb_checker #(.ADDR_W(ADDR_W)) i_btb_checker (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .fetch_hit(fetch_hit),
    .fetch_taken(fetch_taken), .fetch_target(fetch_target),
    .fetch_next_pc(fetch_next_pc), .res_valid(res_valid), .res_pc(res_pc),
    .res_taken(res_taken), .res_is_jump(res_is_jump), .res_hit(res_hit),
    .squash(squash)
);

// File: tb/test_btb.sv
// Bench test_btb
// Directed scenarios, each in its own task that checks its own results.
// Inputs change on the falling edge; results are sampled 1 time unit later.
module test_btb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] fetch_pc;
    logic          fetch_hit, fetch_taken;
    logic [AW-1:0] fetch_target, fetch_next_pc;
    logic          res_valid, res_taken, res_is_jump;
    logic [AW-1:0] res_pc, res_target;
    logic          squash;
    logic [AW-1:0] restart_pc;

    int checks = 0;
    int errors = 0;

    logic          sq_seen;
    logic [AW-1:0] rs_seen;

    btb #(.ADDR_W(AW), .INDEX_W(4)) i_btb (
        .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .fetch_hit(fetch_hit),
        .fetch_taken(fetch_taken), .fetch_target(fetch_target),
        .fetch_next_pc(fetch_next_pc), .res_valid(res_valid), .res_pc(res_pc),
        .res_target(res_target), .res_taken(res_taken), .res_is_jump(res_is_jump),
        .squash(squash), .restart_pc(restart_pc)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input string what,
                         input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Present one resolution for one clock; capture squash/restart before the edge.
    task automatic resolve(input logic [AW-1:0] pc, input logic [AW-1:0] tgt,
                           input logic tk, input logic jmp);
        res_valid = 1'b1; res_pc = pc; res_target = tgt;
        res_taken = tk;   res_is_jump = jmp;
        #1;
        sq_seen = squash;
        rs_seen = restart_pc;
        @(negedge clk);
        res_valid = 1'b0; res_taken = 1'b0; res_is_jump = 1'b0;
    endtask

    task automatic look(input logic [AW-1:0] pc);
        fetch_pc = pc;
        #1;
    endtask

    task automatic t_reset;
        look(32'h1000);
        check("R1", "hit after reset", fetch_hit, 0);
        check("R1", "next pc after reset", fetch_next_pc, 32'h1004);
        check("R11", "taken without hit", fetch_taken, 0);
    endtask

    task automatic t_nt_miss;
        resolve(32'h1100, 32'h2000, 0, 0);
        check("R8", "squash nt miss", sq_seen, 0);
        check("R8", "restart nt", rs_seen, 32'h1104);
        look(32'h1100);
        check("R7", "nt miss not allocated", fetch_hit, 0);
    endtask

    task automatic t_branch_counter;
        resolve(32'h1000, 32'h2000, 1, 0);
        check("R8", "squash taken miss", sq_seen, 1);
        check("R8", "restart taken", rs_seen, 32'h2000);
        look(32'h1000);
        check("R4", "allocated hit", fetch_hit, 1);
        check("R3", "next pc = target", fetch_next_pc, 32'h2000);
        resolve(32'h1000, 32'h2000, 0, 0);       // 2 -> 1
        check("R8", "squash wrong taken guess", sq_seen, 1);
        check("R8", "restart after nt", rs_seen, 32'h1004);
        look(32'h1000);
        check("R4", "weak start flips after one nt", fetch_taken, 0);
        check("R3", "next pc sequential on nt guess", fetch_next_pc, 32'h1004);
        resolve(32'h1000, 32'h2000, 0, 0);       // 1 -> 0
        resolve(32'h1000, 32'h2000, 0, 0);       // stays 0
        check("R8", "no squash on correct nt", sq_seen, 0);
        resolve(32'h1000, 32'h2000, 1, 0);       // 0 -> 1
        look(32'h1000);
        check("R6", "saturated at 0, one taken stays nt", fetch_taken, 0);
        resolve(32'h1000, 32'h2000, 1, 0);       // 1 -> 2
        look(32'h1000);
        check("R6", "two taken from 0 predicts taken", fetch_taken, 1);
    endtask

    task automatic t_saturate_high;
        resolve(32'h1008, 32'h2100, 1, 0);       // alloc 2
        resolve(32'h1008, 32'h2100, 1, 0);       // 3
        check("R8", "no squash on correct taken", sq_seen, 0);
        resolve(32'h1008, 32'h2100, 1, 0);       // stays 3
        resolve(32'h1008, 32'h2100, 0, 0);       // 2
        look(32'h1008);
        check("R6", "saturated at 3, one nt still taken", fetch_taken, 1);
        resolve(32'h1008, 32'h2100, 0, 0);       // 1
        look(32'h1008);
        check("R6", "second nt flips", fetch_taken, 0);
    endtask

    task automatic t_jump;
        resolve(32'h100C, 32'h3000, 1, 1);
        check("R8", "squash jump miss", sq_seen, 1);
        check("R8", "restart jump", rs_seen, 32'h3000);
        look(32'h100C);
        check("R5", "jump predicted taken", fetch_taken, 1);
        resolve(32'h100C, 32'h3000, 0, 0);       // 3 -> 2
        look(32'h100C);
        check("R5", "jump strong start survives one nt", fetch_taken, 1);
        check("R3", "jump next pc", fetch_next_pc, 32'h3000);
    endtask

    task automatic t_alias;
        look(32'h1040);
        check("R2", "alias misses", fetch_hit, 0);
        check("R11", "alias not taken", fetch_taken, 0);
        check("R2", "alias next pc", fetch_next_pc, 32'h1044);
        resolve(32'h1040, 32'h2400, 1, 0);
        look(32'h1000);
        check("R2", "evicted address misses", fetch_hit, 0);
        look(32'h1040);
        check("R2", "new owner hits", fetch_hit, 1);
    endtask

    task automatic t_target_change;
        resolve(32'h1010, 32'h4000, 1, 0);
        resolve(32'h1010, 32'h5000, 1, 0);
        check("R8", "squash on target mismatch", sq_seen, 1);
        check("R8", "restart new target", rs_seen, 32'h5000);
        look(32'h1010);
        check("R9", "target replaced", fetch_target, 32'h5000);
        resolve(32'h1010, 32'h5000, 1, 0);
        check("R8", "no squash on matching target", sq_seen, 0);
    endtask

    task automatic t_same_cycle;
        fetch_pc = 32'h1014;
        resolve(32'h1014, 32'h6000, 1, 0);
        // resolve sampled fetch side too; re-present at the edge boundary
        look(32'h1014);
        check("R10", "hit after write edge", fetch_hit, 1);
        // Same cycle on an existing slot holding counter 1 (0x1008).
        fetch_pc = 32'h1008;
        res_valid = 1'b1; res_pc = 32'h1008; res_target = 32'h2100;
        res_taken = 1'b1; res_is_jump = 1'b0;
        #1;
        check("R10", "same-cycle lookup sees old counter", fetch_taken, 0);
        check("R10", "same-cycle next pc old", fetch_next_pc, 32'h100C);
        @(negedge clk);
        res_valid = 1'b0; res_taken = 1'b0;
        #1;
        check("R10", "new counter visible after edge", fetch_taken, 1);
        // New slot, same cycle: must miss before the edge.
        fetch_pc = 32'h1018;
        res_valid = 1'b1; res_pc = 32'h1018; res_target = 32'h7000;
        res_taken = 1'b1;
        #1;
        check("R10", "same-cycle new slot misses", fetch_hit, 0);
        @(negedge clk);
        res_valid = 1'b0; res_taken = 1'b0;
        #1;
        check("R10", "new slot hits after edge", fetch_hit, 1);
    endtask

    initial begin
        rst_n = 1'b0; fetch_pc = '0; res_valid = 1'b0; res_pc = '0;
        res_target = '0; res_taken = 1'b0; res_is_jump = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_nt_miss();
        t_branch_counter();
        t_saturate_high();
        t_jump();
        t_alias();
        t_target_change();
        t_same_cycle();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule